// File: doc/BRIEF.md
# Receive Symbol Aligner with Bit Jog

This block sits behind a deserializer that delivers 10-bit parallel words with no known word boundary. It joins the previous and current words into a 20-bit window and selects a 10-bit slice from it at a bit offset from 0 to 9. The selected slice is the aligned symbol, which goes to the downstream decoder together with a valid flag and the current offset.

A two-bit mode input controls how the offset is chosen. The offset can be frozen. It can follow comma symbols automatically, so that a comma found at any other offset moves the boundary to that comma. It can also be slipped by a single bit under software or link-training control, one slip for each entry into the slip mode. An optional polarity swap complements the incoming bits before any of this happens, which corrects crossed differential pairs. A receiver enable clears the whole block when low.

Top module: `rx_sym_align`

## Requirements
- R1: While reset is asserted and after it is released, `dout_vld` is 0 and `bit_ofs` is 0.
- R2: When `pol_inv` is 1, every incoming bit is complemented before alignment and comma search. When it is 0, data passes unchanged.
- R3: With `align_mode` = 00, `bit_ofs` never changes, even when commas arrive at another offset.
- R4: `align_mode` = 11 behaves like 00. Entering 11 from 00 causes no slip.
- R5: With `align_mode` = 01, a comma found at an offset other than the current one moves `bit_ofs` to the lowest such offset. A comma is one of the 7-bit patterns 0011111 or 1100000, read in transmission order, where bit 0 of each word is sent first. A comma found at the current offset changes nothing.
- R6: When `align_mode` becomes 10 and its upper bit was 0 at the previous clock edge, `bit_ofs` advances by exactly one. Staying in 10, or moving from 11 to 10, does not advance it.
- R7: A slip from offset 9 wraps the offset to 0.
- R8: After any change of `bit_ofs`, `dout_vld` is 0 for exactly the following cycle.
- R9: While `rx_en` is 0, `dout_vld` is 0 and `bit_ofs` is 0 one cycle later. After `rx_en` rises, two words must be captured before `dout_vld` rises.
- R10: A word captured at clock edge p, together with the word captured at edge p+1, appears on `dout` after edge p+2. `dout` bit j is stream bit (offset + j), counted from bit 0 of the earlier word.
- R11: `bit_ofs` always stays below 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| rx_en | input | 1 | Receiver enable; 0 clears and holds the state |
| pol_inv | input | 1 | Complement incoming bits |
| align_mode | input | 2 | 00 freeze, 01 comma-follow, 10 one-bit slip, 11 freeze |
| din | input | 10 | Raw deserializer word, bit 0 first in time |
| dout | output | 10 | Aligned symbol |
| dout_vld | output | 1 | `dout` holds a valid aligned symbol |
| bit_ofs | output | 4 | Current bit offset, 0 to 9 |

## Verification
The aligner is driven with several input patterns:
- A varying non-periodic word sequence at offset 0. This pins down latency and bit order.
- A repeating comma stream placed at offsets 3, 7, 2 and 5. In the freeze modes this stream shows the offset staying put. In the comma mode it shows that the boundary moves to the right offset.
- The same stream complemented, once corrected by `pol_inv` and once not. The uncorrected case exercises the second comma pattern.
- Ten successive entries into the slip mode. These walk the offset through every value and across the wrap.

Transitions 00→11, 11→10 and staying in 10 are included to separate a true rising edge of the mode's upper bit from a mere level. Disabling the receiver and enabling it again shows that the refill delay is counted again from zero.

// File: rtl/rx_sym_align.sv
module rx_sym_align #(
  parameter int W = 10,
  parameter int CW = 7,
  parameter logic [CW-1:0] COMMA_A = 7'b1111100,
  parameter logic [CW-1:0] COMMA_B = 7'b0000011,
  localparam int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          pol_inv,
  input  logic [1:0]    align_mode,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          dout_vld,
  output logic [OW-1:0] bit_ofs
);

  logic [W-1:0]  cur_q, prev_q, dout_q;
  logic [OW-1:0] ofs_q, ofs_nxt, hit_ofs;
  logic [1:0]    fill_q;
  logic          hi_q, vld_q, hit_any;
  logic [W-1:0]  hit;

  wire [W-1:0]   din_p  = din ^ {W{pol_inv}};
  wire [2*W-1:0] win    = {cur_q, prev_q};
  wire           primed = (fill_q == 2'd2);

  genvar k;
  generate
    for (k = 0; k < W; k++) begin : g_cmp
      assign hit[k] = (win[k +: CW] == COMMA_A) || (win[k +: CW] == COMMA_B);
    end
  endgenerate

  always_comb begin
    hit_any = 1'b0;
    hit_ofs = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_any = 1'b1;
        hit_ofs = OW'(i);
      end
    end
  end

  wire jog     = rx_en && (align_mode == 2'b10) && !hi_q;
  wire realign = rx_en && primed && (align_mode == 2'b01) && hit_any && (hit_ofs != ofs_q);

  always_comb begin
    ofs_nxt = ofs_q;
    if (jog)
      ofs_nxt = (ofs_q == OW'(W - 1)) ? '0 : ofs_q + 1'b1;
    else if (realign)
      ofs_nxt = hit_ofs;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      cur_q  <= '0;
      prev_q <= '0;
      dout_q <= '0;
      fill_q <= '0;
      ofs_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      hi_q <= align_mode[1];
      if (!rx_en) begin
        cur_q  <= '0;
        prev_q <= '0;
        dout_q <= '0;
        fill_q <= '0;
        ofs_q  <= '0;
        vld_q  <= 1'b0;
      end else begin
        cur_q  <= din_p;
        prev_q <= cur_q;
        fill_q <= primed ? fill_q : fill_q + 2'd1;
        ofs_q  <= ofs_nxt;
        dout_q <= win[ofs_q +: W];
        vld_q  <= primed && (ofs_nxt == ofs_q);
      end
    end
  end

  assign dout     = dout_q;
  assign dout_vld = vld_q;
  assign bit_ofs  = ofs_q;

endmodule

// File: rtl/rx_sym_align_chk.sv
module rx_sym_align_chk #(
  parameter int W = 10,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic [1:0]    align_mode,
  input logic          dout_vld,
  input logic [OW-1:0] bit_ofs
);

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ofs < OW'(W)); // R11

  AST_RX_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!dout_vld && bit_ofs == '0)); // R9

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && align_mode == 2'b00) |=> $stable(bit_ofs)); // R3

  AST_RSV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && align_mode == 2'b11) |=> $stable(bit_ofs)); // R4

  AST_GAP_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ofs != $past(bit_ofs)) |-> !dout_vld); // R8

  AST_SLIP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && align_mode == 2'b10 && !$past(align_mode[1]) && bit_ofs != OW'(W - 1))
      |=> bit_ofs == $past(bit_ofs) + 1'b1); // R6

  AST_SLIP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && align_mode == 2'b10 && !$past(align_mode[1]) && bit_ofs == OW'(W - 1))
      |=> bit_ofs == '0); // R7

endmodule

bind rx_sym_align rx_sym_align_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .align_mode(align_mode),
  .dout_vld(dout_vld), .bit_ofs(bit_ofs)
);

// File: tb/rx_sym_align_bench.sv
module rx_sym_align_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       pol_inv = 1'b0;
  logic [1:0] align_mode = 2'b00;
  logic [9:0] din = '0;
  logic [9:0] dout;
  logic       dout_vld;
  logic [3:0] bit_ofs;

  rx_sym_align u_rx_sym_align (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .pol_inv(pol_inv),
    .align_mode(align_mode), .din(din), .dout(dout),
    .dout_vld(dout_vld), .bit_ofs(bit_ofs)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         cyc;
    logic       vld;
    logic       chk_d;
    logic [9:0] d;
    logic [3:0] ofs;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  localparam logic [9:0] COMMA_SYM = 10'b0101111100;

  function automatic logic [9:0] rotl(logic [9:0] v, int s);
    return (v << s) | (v >> (10 - s));
  endfunction

  function automatic logic [9:0] rotr(logic [9:0] v, int s);
    return (s == 0) ? v : ((v >> s) | (v << (10 - s)));
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int c, logic v, logic cd, logic [9:0] d, logic [3:0] o, string tag);
    exp_t e;
    e.cyc = c; e.vld = v; e.chk_d = cd; e.d = d; e.ofs = o; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (e.cyc != cyc || dout_vld !== e.vld || bit_ofs !== e.ofs ||
          (e.chk_d && dout !== e.d)) begin
        n_bad++;
        $display("FAIL %s cyc %0d: vld=%b ofs=%0d dout=%h, expected vld=%b ofs=%0d dout=%h",
                 e.tag, cyc, dout_vld, bit_ofs, dout, e.vld, e.ofs, e.d);
      end
    end
  end

  task automatic nxt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_then_steady(logic [9:0] d, logic [3:0] o, string tag);
    nxt(3);
    for (int i = 1; i <= 2; i++) expect_at(cyc + i, 1'b1, 1'b1, rotr(d, o), o, tag);
    nxt(2);
  endtask

  task automatic comma_lock(logic [9:0] raw, logic inv, logic [3:0] from, int s,
                            logic [9:0] want, string tag);
    align_mode = 2'b00; pol_inv = inv; din = raw;
    settle_then_steady(raw ^ {10{inv}}, from, "R3");
    align_mode = 2'b01;
    expect_at(cyc + 1, 1'b0, 1'b0, '0, 4'(s), "R8");
    for (int i = 2; i <= 4; i++) expect_at(cyc + i, 1'b1, 1'b1, want, 4'(s), tag);
    nxt(4);
  endtask

  initial begin
    int base;
    logic [9:0] stream;
    nxt(2);
    expect_at(cyc + 1, 1'b0, 1'b1, '0, 4'd0, "R1");
    nxt(2);
    rst_n = 1'b1;
    expect_at(cyc + 1, 1'b0, 1'b0, '0, 4'd0, "R1");
    nxt(2);

    // R9 and R10: refill delay, latency and bit order at offset 0
    rx_en = 1'b1;
    base = cyc;
    expect_at(base + 1, 1'b0, 1'b0, '0, 4'd0, "R9");
    expect_at(base + 2, 1'b0, 1'b0, '0, 4'd0, "R9");
    for (int i = 0; i < 6; i++) begin
      din = 10'h2A5 ^ 10'(i * 37);
      if (i < 4) expect_at(base + 3 + i, 1'b1, 1'b1, 10'h2A5 ^ 10'(i * 37), 4'd0, "R10");
      nxt(1);
    end

    // R3: freeze with commas at offset 3
    stream = rotl(COMMA_SYM, 3);
    din = stream;
    settle_then_steady(stream, 4'd0, "R3");
    // R4: reserved mode from freeze
    align_mode = 2'b11;
    for (int i = 1; i <= 3; i++) expect_at(cyc + i, 1'b1, 1'b1, stream, 4'd0, "R4");
    nxt(3);
    // R6: 11 -> 10 is no slip
    align_mode = 2'b10;
    for (int i = 1; i <= 2; i++) expect_at(cyc + i, 1'b1, 1'b1, stream, 4'd0, "R6");
    nxt(2);
    align_mode = 2'b00;
    nxt(2);

    // R6, R7, R8: ten slips
    for (int j = 1; j <= 10; j++) begin
      align_mode = 2'b10;
      expect_at(cyc + 1, 1'b0, 1'b0, '0, 4'(j % 10), "R8");
      expect_at(cyc + 2, 1'b1, 1'b1, rotr(stream, j % 10), 4'(j % 10), (j == 10) ? "R7" : "R6");
      nxt(2);
      align_mode = 2'b00;
      nxt(1);
    end

    // R5: comma-follow to offset 3, then 7
    align_mode = 2'b01;
    expect_at(cyc + 1, 1'b0, 1'b0, '0, 4'd3, "R8");
    for (int i = 2; i <= 4; i++) expect_at(cyc + i, 1'b1, 1'b1, COMMA_SYM, 4'd3, "R5");
    nxt(4);
    comma_lock(rotl(COMMA_SYM, 7), 1'b0, 4'd3, 7, COMMA_SYM, "R5");
    // R2: complemented stream, corrected by polarity swap
    comma_lock(~rotl(COMMA_SYM, 2), 1'b1, 4'd7, 2, COMMA_SYM, "R2");
    // R5: uncorrected complement matches the second comma pattern
    comma_lock(~rotl(COMMA_SYM, 5), 1'b0, 4'd2, 5, ~COMMA_SYM, "R5");

    // R9: disable clears, enable refills
    align_mode = 2'b00;
    rx_en = 1'b0;
    expect_at(cyc + 1, 1'b0, 1'b0, '0, 4'd0, "R9");
    expect_at(cyc + 2, 1'b0, 1'b0, '0, 4'd0, "R9");
    nxt(2);
    rx_en = 1'b1;
    din = 10'h1C3;
    expect_at(cyc + 1, 1'b0, 1'b0, '0, 4'd0, "R9");
    expect_at(cyc + 2, 1'b0, 1'b0, '0, 4'd0, "R9");
    expect_at(cyc + 3, 1'b1, 1'b1, 10'h1C3, 4'd0, "R9");
    nxt(5);

    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R10: %0d expected items never compared, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1: watchdog expired at cycle %0d, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule